// File: doc/BRIEF.md
# Tracking reference ramp controller

This block produces the common reference ramp that up to three supply rails follow during a controlled power-up or power-down. A sequencer supplies the direction, the per-tick step size and a tick-enable pulse. Each accepted tick moves a fixed-point accumulator up or down by the step. The reference in millivolts is the integer part of that accumulator.

Every cycle, the block compares each enabled rail's measured output against the reference. If a rail falls behind in the current direction of travel by more than a narrow window, the ramp pauses until that rail catches up. If a rail strays from the reference by more than a wider window on either side, the block emits a one-cycle fault pulse. The ramp does not move while that condition lasts.

A power-good flag reports when every enabled rail's output has passed 92.5% of its own input voltage. The block does not decide when a phase starts or stops. That decision belongs to the sequencer that drives the direction, tick and clear inputs.

Top module: `trk_ramp_ctrl`

## Requirements
- R1: With `dir_up`=1, `hold` is 1 whenever some enabled channel satisfies ramp − out > 125 (mV codes). A tick in such a cycle leaves `ramp_mv` unchanged. Once every enabled output is within 125 below the ramp, ticks advance it again.
- R2: With `dir_up`=0, `hold` is 1 whenever some enabled channel satisfies out − ramp > 125. A tick in such a cycle leaves `ramp_mv` unchanged.
- R3: An output lying above the ramp never raises `hold` while `dir_up`=1. An output lying below the ramp never raises `hold` while `dir_up`=0.
- R4: In either direction, if some enabled channel differs from the ramp by more than 250, `fault` is high for exactly one cycle, in the cycle after the condition first appears. The ramp does not move in any cycle where the condition is present.
- R5: `pwr_good` (combinational) is 1 exactly when every enabled channel meets out × 40 > in × 37, which is above 92.5% of its input. It is 1 when no channel is enabled.
- R6: A channel whose `chan_en` bit is 0 affects none of `hold`, `fault`, `pwr_good` or the ramp movement.
- R7: On a tick with neither hold nor fault present, the 20-bit accumulator (8 fraction bits) gains `step` (`dir_up`=1) or loses `step` (`dir_up`=0). `ramp_mv` equals the accumulator divided by 256. Without a tick, the ramp stays where it is.
- R8: The accumulator saturates at 0 when ramping down and at all ones (`ramp_mv` = 4095) when ramping up, and never wraps.
- R9: Reset and the synchronous `clr` input set the ramp to 0 and `fault` to 0. `clr` takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous ramp clear |
| tick | input | 1 | Ramp step enable, one pulse per step |
| dir_up | input | 1 | 1 = ramp up, 0 = ramp down |
| step | input | 16 | Step per tick, in 1/256 mV units |
| chan_en | input | 3 | Per-channel enable; bit i controls channel i |
| out_mv | input | 36 | Output samples; channel i at bits [12i+11:12i] |
| in_mv | input | 36 | Input samples; channel i at bits [12i+11:12i] |
| ramp_mv | output | 12 | Reference ramp, in mV |
| hold | output | 1 | Ramp paused for a lagging rail |
| fault | output | 1 | One-cycle tracking fault pulse |
| pwr_good | output | 1 | All enabled outputs above 92.5% of their inputs |

## Verification
A corrupted accumulator shows on `ramp_mv` at the first clock edge after the bad update, because the output is a direct slice of the state. A stuck flag for the previous fault condition shows as a missing or repeated `fault` pulse one cycle after a window violation. The hold and power-good decisions are combinational. Errors in the window arithmetic or in channel masking therefore appear in the same cycle the stimulus is applied. They also appear on the next tick as a ramp that moved when it should have paused, or paused when it should have moved.

// File: rtl/trk_pkg.sv
package trk_pkg;
    localparam int unsigned HOLD_MV  = 125;
    localparam int unsigned FAULT_MV = 250;
    localparam int unsigned PG_NUM   = 37;
    localparam int unsigned PG_DEN   = 40;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ramp_dir_e;
endpackage

// File: rtl/trk_chan_mon.sv
module trk_chan_mon
    import trk_pkg::*;
#(
    parameter int VW = 12
) (
    input  logic          en,
    input  logic [VW-1:0] ramp_mv,
    input  logic [VW-1:0] out_mv,
    input  logic [VW-1:0] in_mv,
    output logic          lag_below,
    output logic          lag_above,
    output logic          out_of_win,
    output logic          at_target
);
    localparam int EW = VW + 2;
    localparam int PW = VW + 7;

    logic [EW-1:0] r_ext;
    logic [EW-1:0] o_ext;
    logic [PW-1:0] o_scaled;
    logic [PW-1:0] i_scaled;

    always_comb begin
        r_ext    = EW'(ramp_mv);
        o_ext    = EW'(out_mv);
        o_scaled = PW'(out_mv) * PW'(PG_DEN);
        i_scaled = PW'(in_mv) * PW'(PG_NUM);

        lag_below  = en && (r_ext > o_ext + EW'(HOLD_MV));
        lag_above  = en && (o_ext > r_ext + EW'(HOLD_MV));
        out_of_win = en && ((r_ext > o_ext + EW'(FAULT_MV)) ||
                            (o_ext > r_ext + EW'(FAULT_MV)));
        at_target  = !en || (o_scaled > i_scaled);
    end
endmodule

// File: rtl/trk_step_acc.sv
module trk_step_acc #(
    parameter int AW = 20,
    parameter int SW = 16
) (
    input  logic [AW-1:0] acc_q,
    input  logic [SW-1:0] step,
    input  logic          dir_up,
    input  logic          advance,
    output logic [AW-1:0] acc_nxt
);
    logic [AW:0] sum_w;
    logic [AW:0] step_w;

    always_comb begin
        step_w  = (AW+1)'(step);
        sum_w   = {1'b0, acc_q} + step_w;
        acc_nxt = acc_q;
        if (advance) begin
            if (dir_up) begin
                acc_nxt = sum_w[AW] ? {AW{1'b1}} : sum_w[AW-1:0];
            end else begin
                acc_nxt = (step_w > {1'b0, acc_q}) ? '0
                                                   : acc_q - AW'(step);
            end
        end
    end
endmodule

// File: rtl/trk_ramp_ctrl.sv
module trk_ramp_ctrl
    import trk_pkg::*;
#(
    parameter int NCH = 3,
    parameter int VW  = 12,
    parameter int FW  = 8,
    parameter int SW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              dir_up,
    input  logic [SW-1:0]     step,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*VW-1:0] out_mv,
    input  logic [NCH*VW-1:0] in_mv,
    output logic [VW-1:0]     ramp_mv,
    output logic              hold,
    output logic              fault,
    output logic              pwr_good
);
    localparam int AW = VW + FW;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          flt_prev;
        logic          fault;
    } state_t;

    state_t state_d, state_q;

    logic [NCH-1:0] below_v, above_v, flt_v, pg_v;
    logic           any_flt;
    logic           advance;
    logic [AW-1:0]  acc_step;
    ramp_dir_e      dir_e;

    assign ramp_mv = state_q.acc[AW-1:FW];
    assign fault   = state_q.fault;
    assign dir_e   = dir_up ? DIR_UP : DIR_DOWN;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        trk_chan_mon #(.VW(VW)) u_mon (
            .en         (chan_en[g]),
            .ramp_mv    (ramp_mv),
            .out_mv     (out_mv[g*VW +: VW]),
            .in_mv      (in_mv[g*VW +: VW]),
            .lag_below  (below_v[g]),
            .lag_above  (above_v[g]),
            .out_of_win (flt_v[g]),
            .at_target  (pg_v[g])
        );
    end

    always_comb begin
        hold     = (dir_e == DIR_UP) ? |below_v : |above_v;
        any_flt  = |flt_v;
        pwr_good = &pg_v;
        advance  = tick && !hold && !any_flt;
    end

    trk_step_acc #(.AW(AW), .SW(SW)) u_acc (
        .acc_q   (state_q.acc),
        .step    (step),
        .dir_up  (dir_up),
        .advance (advance),
        .acc_nxt (acc_step)
    );

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = '0;
        end else begin
            state_d.acc      = acc_step;
            state_d.flt_prev = any_flt;
            state_d.fault    = any_flt && !state_q.flt_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !clr |=> $stable(ramp_mv)); // R1

    AST_UP_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_up && !clr |=> ramp_mv >= $past(ramp_mv)); // R7

    AST_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_up && !clr |=> ramp_mv <= $past(ramp_mv)); // R8

    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault); // R4

    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(ramp_mv)); // R4

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ramp_mv == '0) && !fault); // R9

    AST_PG_NONE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en == '0 |-> pwr_good); // R5
endmodule

// File: tb/trk_ramp_ctrl_tb.sv
module trk_ramp_ctrl_tb;
    localparam int CLK_NS = 10;
    localparam int NCH = 3;
    localparam int VW  = 12;
    localparam int FW  = 8;
    localparam int SW  = 16;
    localparam int AW  = VW + FW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              tick = 1'b0;
    logic              dir_up = 1'b1;
    logic [SW-1:0]     step = '0;
    logic [NCH-1:0]    chan_en = '0;
    logic [NCH*VW-1:0] out_mv = '0;
    logic [NCH*VW-1:0] in_mv = '0;
    logic [VW-1:0]     ramp_mv;
    logic              hold, fault, pwr_good;

    int n_run = 0;
    int n_fail = 0;
    logic [AW-1:0] m_acc = '0;
    logic          m_prev = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    trk_ramp_ctrl #(.NCH(NCH), .VW(VW), .FW(FW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .dir_up(dir_up),
        .step(step), .chan_en(chan_en), .out_mv(out_mv), .in_mv(in_mv),
        .ramp_mv(ramp_mv), .hold(hold), .fault(fault), .pwr_good(pwr_good)
    );

    typedef struct packed {
        logic               c;
        logic               t;
        logic               up;
        logic [15:0]        st;
        logic [2:0]         en;
        logic signed [12:0] o0;
        logic signed [12:0] o1;
        logic signed [12:0] o2;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 16'd0,     3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b0, 1'b1, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, -13'sd126, 13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, -13'sd125, 13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd200,  13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd0,    -13'sd251, 13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b111, 13'sd0,    -13'sd251, 13'sd0},
        '{1'b0, 1'b1, 1'b1, 16'd25600, 3'b101, 13'sd0,    13'sd251,  13'sd0},
        '{1'b0, 1'b1, 1'b0, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd126},
        '{1'b0, 1'b1, 1'b0, 16'd25600, 3'b111, 13'sd0,    13'sd0,    -13'sd200},
        '{1'b0, 1'b1, 1'b0, 16'd25600, 3'b111, 13'sd0,    13'sd251,  13'sd0},
        '{1'b0, 1'b1, 1'b0, 16'd25600, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b0, 16'd65535, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b0, 16'd65535, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b0, 1'b1, 1'b0, 16'd65535, 3'b111, 13'sd0,    13'sd0,    13'sd0},
        '{1'b1, 1'b1, 1'b1, 16'd65535, 3'b111, 13'sd0,    13'sd0,    13'sd0}
    };

    function automatic string vec_tag(int k);
        case (k)
            0, 19:          return "R9";
            6, 7:           return "R1";
            8, 13:          return "R3";
            9, 10, 14:      return "R4";
            11:             return "R6";
            12:             return "R2";
            16, 17, 18:     return "R8";
            default:        return "R7";
        endcase
    endfunction

    function automatic int clip(int v);
        if (v < 0) return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag, bit c, bit t, bit up, int st, int en,
                         int o0, int o1, int o2, int i0, int i1, int i2);
        int o [3];
        int vi [3];
        int r;
        bit below, above, aflt, pg, h;
        o[0] = o0; o[1] = o1; o[2] = o2;
        vi[0] = i0; vi[1] = i1; vi[2] = i2;
        @(negedge clk);
        clr = c; tick = t; dir_up = up; step = SW'(st); chan_en = NCH'(en);
        out_mv = {12'(o2), 12'(o1), 12'(o0)};
        in_mv  = {12'(i2), 12'(i1), 12'(i0)};
        r = int'(m_acc >> FW);
        below = 0; above = 0; aflt = 0; pg = 1;
        for (int i = 0; i < 3; i++) begin
            if (en[i]) begin
                if (r > o[i] + 125) below = 1;
                if (o[i] > r + 125) above = 1;
                if ((r > o[i] + 250) || (o[i] > r + 250)) aflt = 1;
                if (!(o[i] * 40 > vi[i] * 37)) pg = 0;
            end
        end
        h = up ? below : above;
        #1;
        check(tag, "hold", int'(hold), int'(h));
        check(tag, "pwr_good", int'(pwr_good), int'(pg));
        @(posedge clk);
        if (c) begin
            m_acc = '0;
            m_prev = 0;
        end else begin
            if (t && !h && !aflt) begin
                if (up) begin
                    if (int'(m_acc) + st > (1 << AW) - 1) m_acc = '1;
                    else m_acc = m_acc + AW'(st);
                end else begin
                    if (st > int'(m_acc)) m_acc = '0;
                    else m_acc = m_acc - AW'(st);
                end
            end
        end
        #1;
        check(tag, "ramp_mv", int'(ramp_mv), int'(m_acc >> FW));
        check(tag, "fault", int'(fault), int'(aflt && !m_prev && !c));
        if (!c) m_prev = aflt;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset ramp", int'(ramp_mv), 0);
        check("R9", "reset fault", int'(fault), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            int r;
            r = int'(m_acc >> FW);
            cycle(vec_tag(k), VECS[k].c, VECS[k].t, VECS[k].up, int'(VECS[k].st),
                  int'(VECS[k].en),
                  clip(r + int'(VECS[k].o0)), clip(r + int'(VECS[k].o1)),
                  clip(r + int'(VECS[k].o2)), 4095, 4095, 4095);
        end

        // R8: upward saturation with rails following the ramp
        for (int k = 0; k < 18; k++) begin
            int r;
            r = int'(m_acc >> FW);
            cycle("R8", 1'b0, 1'b1, 1'b1, 65535, 7, r, r, r, 4095, 4095, 4095);
        end
        check("R8", "ramp at top", int'(ramp_mv), 4095);

        // R5: power-good threshold at 92.5 percent
        cycle("R5", 1'b0, 1'b0, 1'b1, 0, 7, 926, 4000, 4000, 1000, 4000, 4000);
        cycle("R5", 1'b0, 1'b0, 1'b1, 0, 7, 925, 4000, 4000, 1000, 4000, 4000);
        // R6: disabled channel ignored for power-good and fault
        cycle("R6", 1'b0, 1'b0, 1'b1, 0, 6, 0, 4000, 4000, 1000, 4000, 4000);
        cycle("R5", 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 4000, 4000, 4000);
        // R4: fault in downward direction, rail far above a low ramp
        cycle("R9", 1'b1, 1'b0, 1'b0, 0, 7, 0, 0, 0, 4095, 4095, 4095);
        cycle("R4", 1'b0, 1'b1, 1'b0, 256, 7, 0, 300, 0, 4095, 4095, 4095);
        cycle("R4", 1'b0, 1'b1, 1'b0, 256, 7, 0, 0, 0, 4095, 4095, 4095);
        // R9: clear wins over a tick
        cycle("R7", 1'b0, 1'b1, 1'b1, 51200, 7, 0, 0, 0, 4095, 4095, 4095);
        cycle("R9", 1'b1, 1'b1, 1'b1, 51200, 7, 200, 200, 200, 4095, 4095, 4095);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule